// File: doc/BRIEF.md
# Six-Master Locking Bus Arbiter

This block chooses which of six bus masters drives a shared system bus. Each master raises a request line, and optionally a lock line when it needs several transfers in a row without interruption. The arbiter works in two phases. In a decide cycle it moves the one-hot grant lines and captures the chosen master's lock wish. Later, in a start cycle, ownership (the current-master index and the master-lock flag) moves to match. A transfer is slowed by holding the ready input low, and that delays the hand-over. A four-beat burst must finish before the next decision is taken.

The selection is round-robin among masters 1 to 5, starting just after the master that holds the grant now. Master 0 is the default owner. It is picked only when none of masters 1 to 5 is requesting, and it is granted and owns the bus out of reset. The decide, start and locked handshake signals are brought out as ports so that the surrounding logic and checkers can observe the phase sequence.

Top module: `lock_arbiter`

## Requirements
- R1: While reset is asserted, and right after it is released, `grant` is 6'b000001, `owner` is 0, and `owner_lock`, `locked` and `start` are 0.
- R2: `decide` is high in a cycle only when all of these are true: `hready` is high, no hand-over is pending, `start` is low, no four-beat burst is in progress, and the granted master is not both locked and still requesting. A granted master that holds the lock and keeps its request raised keeps the bus indefinitely.
- R3: In the cycle after `decide`, `grant` selects the first requesting master among 1 to 5. The search starts just after the currently granted index and wraps from 5 back to 1. If none of masters 1 to 5 is requesting, master 0 is granted.
- R4: In the cycle after a cycle with `decide` low, `grant` and `locked` keep their values.
- R5: In the cycle after `decide`, `locked` equals the lock input of the newly selected master, as sampled in the decide cycle.
- R6: In the cycle after a cycle with `hready` high, `owner` equals the index of the master that was granted, and `owner_lock` equals the value `locked` had.
- R7: `start` is high in cycle t exactly when `hready` was high in cycle t-1 and a decision that changed the grant or the lock was still waiting for hand-over. When `start` is low, `owner` and `owner_lock` hold their previous values.
- R8: If `burst` is 2'b01 (four beats) in a start cycle, the start cycle counts as the first beat, and each later cycle with `hready` high counts one more beat. Until the fourth beat has been counted, neither `decide` nor `start` is asserted. Any other `burst` value is a single transfer, and no beats are tracked for it.
- R9: `busreq` equals the request line of the master whose index is on `owner`.
- R10: `grant` always has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hready | input | 1 | The current transfer completes in this cycle |
| req | input | 6 | Request line per master (bit i = master i) |
| lock | input | 6 | Lock wish per master; high only while that master's request is high |
| burst | input | 2 | Burst kind of the starting transfer: 2'b01 four-beat, others single |
| grant | output | 6 | One-hot grant lines |
| owner | output | 3 | Binary index of the master that owns the bus |
| owner_lock | output | 1 | The owning master holds the bus locked |
| busreq | output | 1 | Request line of the owning master |
| decide | output | 1 | Decision cycle: grant and locked may change next cycle |
| start | output | 1 | Hand-over cycle: owner and owner_lock took new values |
| locked | output | 1 | Lock wish captured at the last decision |

## Verification
The hardest situation to reach is a four-beat burst that stalls on a low `hready` while the locked owner drops its request. In that case `decide` must stay low because beats are still owed, even though the lock no longer holds the bus. The stimulus table launches a four-beat burst for a locked master, inserts a wait cycle, and lowers that master's request and lock on the last owed beat. A premature decision would show up there as a stray `decide`. Directed sequences then check the round-robin wrap that skips master 0, the indefinite hold by a locked requester, and grants frozen while `hready` stays low.

// File: rtl/lock_arb_pkg.sv
package lock_arb_pkg;

  // Burst kind presented with a starting transfer.
  typedef enum logic [1:0] {
    BT_SINGLE = 2'b00,
    BT_FOUR   = 2'b01,
    BT_RSVD2  = 2'b10,
    BT_RSVD3  = 2'b11
  } burst_e;

  // Beats owed by a four-beat burst, counting the start cycle.
  localparam int FOUR_BEATS = 4;

endpackage

// File: rtl/arb_rr_select.sv
module arb_rr_select #(
  parameter int N  = 6,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic [IW-1:0] pick
);
  // Round-robin over masters 1..N-1; master 0 is the fallback.
  localparam int R = N - 1;

  int   base;
  int   pos;
  logic found;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    pos   = 0;
    base  = (last == '0) ? (R - 1) : (int'(last) - 1);
    for (int k = 1; k <= R; k++) begin
      pos = base + k;
      if (pos >= R) pos = pos - R;
      if (!found && req[pos + 1]) begin
        pick  = IW'(pos + 1);
        found = 1'b1;
      end
    end
  end

endmodule

// File: rtl/arb_burst_track.sv
module arb_burst_track
  import lock_arb_pkg::*;
#(
  parameter int BEATS = FOUR_BEATS,
  localparam int CW   = $clog2(BEATS)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hready,
  input  logic       start,
  input  logic [1:0] burst,
  output logic       idle
);
  logic [CW-1:0] beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
    end else if (start && burst == BT_FOUR) begin
      beat_q <= CW'(1);
    end else if (beat_q != '0 && hready) begin
      beat_q <= (beat_q == CW'(BEATS - 1)) ? '0 : beat_q + CW'(1);
    end
  end

  assign idle = (beat_q == '0);

  AST_NO_START_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> beat_q == '0); // R8

endmodule

// File: rtl/arb_handover.sv
module arb_handover #(
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hready,
  input  logic          decide,
  input  logic          changed,
  input  logic [IW-1:0] gidx,
  input  logic          locked,
  output logic [IW-1:0] owner,
  output logic          owner_lock,
  output logic          start,
  output logic          pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner      <= '0;
      owner_lock <= 1'b0;
      start      <= 1'b0;
      pend       <= 1'b0;
    end else begin
      start <= pend && hready;
      if (decide && changed) pend <= 1'b1;
      else if (hready)       pend <= 1'b0;
      if (hready) begin
        owner      <= gidx;
        owner_lock <= locked;
      end
    end
  end

  AST_START_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> $past(hready)); // R7
  AST_OWNER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !start |-> ($stable(owner) && $stable(owner_lock))); // R7
  AST_OWNER_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    hready |=> owner == $past(gidx)); // R6
  AST_OLOCK_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    hready |=> owner_lock == $past(locked)); // R6

endmodule

// File: rtl/lock_arbiter.sv
module lock_arbiter
  import lock_arb_pkg::*;
#(
  parameter int  N     = 6,
  parameter int  BEATS = FOUR_BEATS,
  localparam int IW    = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hready,
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  lock,
  input  logic [1:0]    burst,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] owner,
  output logic          owner_lock,
  output logic          busreq,
  output logic          decide,
  output logic          start,
  output logic          locked
);
  logic [IW-1:0] gidx;
  logic [IW-1:0] pick;
  logic          pick_lock;
  logic          changed;
  logic          pend;
  logic          burst_idle;
  logic          lock_hold;

  // Binary index of the one-hot grant.
  always_comb begin
    gidx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) gidx = IW'(i);
    end
  end

  arb_rr_select #(.N(N), .IW(IW)) u_sel (
    .req  (req),
    .last (gidx),
    .pick (pick)
  );

  arb_burst_track #(.BEATS(BEATS)) u_burst (
    .clk    (clk),
    .rst_n  (rst_n),
    .hready (hready),
    .start  (start),
    .burst  (burst),
    .idle   (burst_idle)
  );

  arb_handover #(.IW(IW)) u_hand (
    .clk        (clk),
    .rst_n      (rst_n),
    .hready     (hready),
    .decide     (decide),
    .changed    (changed),
    .gidx       (gidx),
    .locked     (locked),
    .owner      (owner),
    .owner_lock (owner_lock),
    .start      (start),
    .pend       (pend)
  );

  assign pick_lock = lock[pick];
  assign lock_hold = locked && req[gidx];
  assign decide    = hready && !pend && !start && burst_idle && !lock_hold;
  assign changed   = (pick != gidx) || (pick_lock != locked);
  assign busreq    = req[owner];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant  <= N'(1);
      locked <= 1'b0;
    end else if (decide) begin
      grant  <= N'(1) << pick;
      locked <= pick_lock;
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant) == 1); // R10
  AST_HOLD_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !decide |=> ($stable(grant) && $stable(locked))); // R4
  AST_LOCK_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    decide |=> locked == $past(pick_lock)); // R5
  AST_DEFAULT_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && req == '0) |=> grant == N'(1)); // R3

endmodule

// File: tb/sim_lock_arbiter.sv
`timescale 1ns/1ps
module sim_lock_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hready = 1'b0;
  logic [5:0] req = '0;
  logic [5:0] lock = '0;
  logic [1:0] burst = '0;
  logic [5:0] grant;
  logic [2:0] owner;
  logic       owner_lock, busreq, decide, start, locked;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  lock_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .hready(hready), .req(req), .lock(lock),
    .burst(burst), .grant(grant), .owner(owner), .owner_lock(owner_lock),
    .busreq(busreq), .decide(decide), .start(start), .locked(locked)
  );

  // {hready, req, lock, burst, | decide, grant, owner, start, locked, owner_lock, busreq}
  localparam int NV = 15;
  localparam logic [28:0] VEC [NV] = '{
    {1'b1, 6'b000000, 6'b000000, 2'b00, 1'b1, 6'b000001, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    {1'b1, 6'b000100, 6'b000100, 2'b00, 1'b1, 6'b000001, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    {1'b1, 6'b000100, 6'b000100, 2'b00, 1'b0, 6'b000100, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0},
    {1'b1, 6'b000110, 6'b000100, 2'b01, 1'b0, 6'b000100, 3'd2, 1'b1, 1'b1, 1'b1, 1'b1},
    {1'b1, 6'b000110, 6'b000100, 2'b01, 1'b0, 6'b000100, 3'd2, 1'b0, 1'b1, 1'b1, 1'b1},
    {1'b0, 6'b000110, 6'b000100, 2'b01, 1'b0, 6'b000100, 3'd2, 1'b0, 1'b1, 1'b1, 1'b1},
    {1'b1, 6'b000110, 6'b000100, 2'b01, 1'b0, 6'b000100, 3'd2, 1'b0, 1'b1, 1'b1, 1'b1},
    {1'b1, 6'b000010, 6'b000000, 2'b00, 1'b0, 6'b000100, 3'd2, 1'b0, 1'b1, 1'b1, 1'b0},
    {1'b1, 6'b000010, 6'b000000, 2'b00, 1'b1, 6'b000100, 3'd2, 1'b0, 1'b1, 1'b1, 1'b0},
    {1'b0, 6'b000010, 6'b000000, 2'b00, 1'b0, 6'b000010, 3'd2, 1'b0, 1'b0, 1'b1, 1'b0},
    {1'b1, 6'b000010, 6'b000000, 2'b00, 1'b0, 6'b000010, 3'd2, 1'b0, 1'b0, 1'b1, 1'b0},
    {1'b1, 6'b000010, 6'b000000, 2'b00, 1'b0, 6'b000010, 3'd1, 1'b1, 1'b0, 1'b0, 1'b1},
    {1'b1, 6'b000000, 6'b000000, 2'b00, 1'b1, 6'b000010, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0},
    {1'b1, 6'b000000, 6'b000000, 2'b00, 1'b0, 6'b000001, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0},
    {1'b1, 6'b000000, 6'b000000, 2'b00, 1'b0, 6'b000001, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wait_decide();
    for (int w = 0; w < 20 && !decide; w++) begin
      step();
      #1;
    end
  endtask

  task automatic chk_reset();
    chk("R1 grant", 32'(grant), 32'h1);
    chk("R1 owner", 32'(owner), 32'h0);
    chk("R1 owner_lock", 32'(owner_lock), 32'h0);
    chk("R1 locked", 32'(locked), 32'h0);
    chk("R1 start", 32'(start), 32'h0);
  endtask

  initial begin
    repeat (3) step();
    #1;
    chk_reset();
    rst_n = 1'b1;

    // Stimulus table: a locked four-beat burst with a stall, then hand-overs.
    for (int v = 0; v < NV; v++) begin
      step();
      {hready, req, lock, burst} = VEC[v][28:14];
      #1;
      chk("R2/R8 decide", 32'(decide), 32'(VEC[v][13]));
      chk("R3 grant", 32'(grant), 32'(VEC[v][12:7]));
      chk("R6 owner", 32'(owner), 32'(VEC[v][6:4]));
      chk("R7 start", 32'(start), 32'(VEC[v][3]));
      chk("R5 locked", 32'(locked), 32'(VEC[v][2]));
      chk("R6 owner_lock", 32'(owner_lock), 32'(VEC[v][1]));
      chk("R9 busreq", 32'(busreq), 32'(VEC[v][0]));
    end

    // R1: reset again and check the idle state.
    step();
    rst_n = 1'b0;
    hready = 1'b1; req = '0; lock = '0; burst = 2'b00;
    step();
    #1;
    chk_reset();
    rst_n = 1'b1;

    // R3: all request; round-robin visits 1..5 and wraps past master 0.
    req = 6'b111111;
    for (int n = 0; n < 6; n++) begin
      int e;
      e = (n % 5) + 1;
      wait_decide();
      step();
      #1;
      chk("R3 rr grant", 32'(grant), 32'(6'b1 << e));
    end

    // R3: only master 0 requests.
    req = 6'b000001;
    wait_decide();
    step();
    #1;
    chk("R3 master0 grant", 32'(grant), 32'h1);

    // R5 and R2: master 3 locks and keeps the bus while master 4 waits.
    req = 6'b011000; lock = 6'b001000;
    wait_decide();
    step();
    #1;
    chk("R5 lock grant", 32'(grant), 32'(6'b001000));
    chk("R5 locked", 32'(locked), 32'h1);
    for (int c = 0; c < 6; c++) begin
      step();
      #1;
      chk("R2 lock hold decide", 32'(decide), 32'h0);
      chk("R2 lock hold grant", 32'(grant), 32'(6'b001000));
    end
    chk("R6 owner locked master", 32'(owner), 32'd3);
    chk("R6 owner_lock set", 32'(owner_lock), 32'h1);
    req = 6'b010000; lock = '0;
    #1;
    chk("R2 release decide", 32'(decide), 32'h1);
    step();
    #1;
    chk("R3 next after lock", 32'(grant), 32'(6'b010000));
    chk("R5 unlocked", 32'(locked), 32'h0);

    // R4: hready low freezes grant and locked while inputs move.
    hready = 1'b0;
    for (int c = 0; c < 4; c++) begin
      req  = (c % 2 == 0) ? 6'b100001 : 6'b000110;
      lock = (c % 2 == 0) ? 6'b100000 : 6'b000100;
      step();
      #1;
      chk("R4 decide low", 32'(decide), 32'h0);
      chk("R4 grant held", 32'(grant), 32'(6'b010000));
      chk("R4 locked held", 32'(locked), 32'h0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule